// File: doc/BRIEF.md
# Command Stream Method Sequencer

This block turns one command-buffer header plus the argument words that follow it into a series of single register writes. A header gives a base method address, a subchannel, an argument count, a submission mode and a 13-bit inline immediate. The header arrives on a valid/ready port. Argument words arrive on a second valid/ready port. Each emitted write carries four things: a method address, the header's subchannel, a data word, and the number of argument words still to come after it.

The submission mode decides how the arguments map to method addresses. The address can step by one per word, stay fixed, or step once after the first word. An inline header instead produces one write from its immediate field. Whoever drives the header port waits for `busy` to fall. This happens when the last write of the previous header has been taken downstream.

Top module: `cmd_method_seq`

## Requirements
- R1: With mode code 0 (stepping), argument word i of a header is written to method address base+i, modulo 2^MTHD_W.
- R2: With mode code 1 (fixed), every argument word of a header is written to the base method address.
- R3: With mode code 2 (step once), argument word 0 goes to the base address and every later word goes to base+1.
- R4: With mode code 3 (inline), no argument word is consumed. Exactly one write is issued to the base address. Its data is the 13-bit immediate, zero-extended, and its remaining count is 0.
- R5: For word i of an N-word header, the remaining count sent with the write is N-i-1, so the final write carries 0 and the block is idle in the cycle after that write is accepted.
- R6: Every write carries the subchannel given in its header.
- R7: A mode 0 or mode 1 header with a count of 0 emits no write, raises no error and leaves the block idle.
- R8: While a header's writes are still pending, `busy` is high and `hdr_ready` is low. `hdr_ready` stays low while an output write is waiting.
- R9: When the write output is back-pressured, argument consumption stalls and the waiting write holds steady. Every argument word is written exactly once and in order.
- R10: A mode 2 header with a count of 0 emits nothing and raises `err` for one cycle.
- R11: A header with mode code 4 to 7 emits nothing, consumes no argument word and raises `err` for one cycle.
- R12: After reset, `wr_valid`, `busy`, `err` and `arg_ready` are low and `hdr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| hdr_method | input | MTHD_W | Base method address |
| hdr_subch | input | SUB_W | Subchannel |
| hdr_count | input | CNT_W | Argument word count |
| hdr_mode | input | 3 | Submission mode code |
| hdr_imm | input | IMM_W | Inline immediate |
| arg_valid | input | 1 | Argument word offered |
| arg_ready | output | 1 | Argument word taken this cycle when valid |
| arg_data | input | DATA_W | Argument word |
| wr_valid | output | 1 | Write transaction present |
| wr_ready | input | 1 | Downstream takes the write |
| wr_method | output | MTHD_W | Write method address |
| wr_subch | output | SUB_W | Write subchannel |
| wr_data | output | DATA_W | Write data |
| wr_remain | output | CNT_W | Argument words still to follow |
| busy | output | 1 | Header in progress or write pending |
| err | output | 1 | One-cycle pulse for a rejected header |

## Verification
Suppose the word index or remaining counter goes out of step. Then the next accepted write shows a wrong method address or remaining count at the output. The error appears on the first write after the fault. A header that finishes late or early also shows up on the ports. `busy` would stay high after a write with remaining count 0, or would fall while arguments are still owed. Either shows within one cycle of that write being accepted. A stall that loses or repeats a word changes the sequence of written data, or the count of consumed arguments, for that same header.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  typedef enum logic [2:0] {
    MODE_STEP = 3'd0,
    MODE_FIX  = 3'd1,
    MODE_ONCE = 3'd2,
    MODE_IMM  = 3'd3
  } seq_mode_e;
endpackage

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
  import cmdseq_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_fire,
  input  logic [2:0]       hdr_mode,
  input  logic [CNT_W-1:0] hdr_count,
  input  logic             arg_fire,
  output logic             running,
  output logic [2:0]       run_mode,
  output logic [CNT_W-1:0] idx,
  output logic [CNT_W-1:0] rem,
  output logic             err,
  output logic             imm_fire
);

  logic cnt_zero;

  assign cnt_zero = (hdr_count == '0);
  assign imm_fire = hdr_fire && (hdr_mode == MODE_IMM);

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      run_mode <= MODE_STEP;
      idx      <= '0;
      rem      <= '0;
      err      <= 1'b0;
    end else begin
      err <= 1'b0;
      if (hdr_fire) begin
        case (hdr_mode)
          MODE_STEP, MODE_FIX, MODE_ONCE: begin
            if (cnt_zero) begin
              err <= (hdr_mode == MODE_ONCE);
            end else begin
              running  <= 1'b1;
              run_mode <= hdr_mode;
              idx      <= '0;
              rem      <= hdr_count - CNT_W'(1);
            end
          end
          MODE_IMM: ;
          default: err <= 1'b1;
        endcase
      end else if (arg_fire) begin
        idx <= idx + CNT_W'(1);
        rem <= rem - CNT_W'(1);
        if (rem == '0) running <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmdseq_addr.sv
module cmdseq_addr
  import cmdseq_pkg::*;
#(
  parameter int MTHD_W = 13,
  parameter int CNT_W  = 13
) (
  input  logic [2:0]        mode,
  input  logic [MTHD_W-1:0] base,
  input  logic [CNT_W-1:0]  idx,
  output logic [MTHD_W-1:0] mthd
);

  always_comb begin
    case (mode)
      MODE_FIX:  mthd = base;
      MODE_ONCE: mthd = (idx == '0) ? base : base + MTHD_W'(1);
      default:   mthd = base + MTHD_W'(idx);
    endcase
  end

endmodule

// File: rtl/cmdseq_obuf.sv
module cmdseq_obuf #(
  parameter int PW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [PW-1:0] dout,
  output logic          space
);

  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cmd_method_seq.sv
module cmd_method_seq
  import cmdseq_pkg::*;
#(
  parameter int MTHD_W = 13,
  parameter int SUB_W  = 3,
  parameter int CNT_W  = 13,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [MTHD_W-1:0] hdr_method,
  input  logic [SUB_W-1:0]  hdr_subch,
  input  logic [CNT_W-1:0]  hdr_count,
  input  logic [2:0]        hdr_mode,
  input  logic [IMM_W-1:0]  hdr_imm,
  input  logic              arg_valid,
  output logic              arg_ready,
  input  logic [DATA_W-1:0] arg_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [MTHD_W-1:0] wr_method,
  output logic [SUB_W-1:0]  wr_subch,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  wr_remain,
  output logic              busy,
  output logic              err
);

  localparam int PW = MTHD_W + SUB_W + DATA_W + CNT_W;

  logic              hdr_fire, arg_fire, imm_fire, running, space;
  logic [2:0]        run_mode;
  logic [CNT_W-1:0]  idx, rem;
  logic [MTHD_W-1:0] base_q, gen_mthd;
  logic [SUB_W-1:0]  subch_q;
  logic [PW-1:0]     pay_in, pay_out;

  assign hdr_ready = !running && !wr_valid;
  assign busy      = running || wr_valid;
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign arg_ready = running && space;
  assign arg_fire  = arg_valid && arg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      subch_q <= '0;
    end else if (hdr_fire) begin
      base_q  <= hdr_method;
      subch_q <= hdr_subch;
    end
  end

  cmdseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .hdr_fire(hdr_fire), .hdr_mode(hdr_mode),
    .hdr_count(hdr_count), .arg_fire(arg_fire), .running(running),
    .run_mode(run_mode), .idx(idx), .rem(rem), .err(err), .imm_fire(imm_fire)
  );

  cmdseq_addr #(.MTHD_W(MTHD_W), .CNT_W(CNT_W)) u_addr (
    .mode(run_mode), .base(base_q), .idx(idx), .mthd(gen_mthd)
  );

  always_comb begin
    if (imm_fire)
      pay_in = {hdr_method, hdr_subch, DATA_W'(hdr_imm), CNT_W'(0)};
    else
      pay_in = {gen_mthd, subch_q, arg_data, rem};
  end

  cmdseq_obuf #(.PW(PW)) u_obuf (
    .clk(clk), .rst(rst), .load(arg_fire || imm_fire), .din(pay_in),
    .out_ready(wr_ready), .out_valid(wr_valid), .dout(pay_out), .space(space)
  );

  assign {wr_method, wr_subch, wr_data, wr_remain} = pay_out;

endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk #(
  parameter int MTHD_W = 13,
  parameter int CNT_W  = 13,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic              arg_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [MTHD_W-1:0] wr_method,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  wr_remain,
  input logic              busy,
  input logic              err
);

  AST_STALL_NO_ARG: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |-> !arg_ready); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_method)
                              && $stable(wr_remain)); // R9
  AST_HDR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    wr_valid || arg_ready |-> !hdr_ready); // R8
  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready && wr_remain == '0 |=> !busy); // R5
  AST_ERR_FROM_HDR: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(hdr_valid && hdr_ready)); // R10
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> !wr_valid && !busy); // R11

endmodule

bind cmd_method_seq cmdseq_chk #(.MTHD_W(MTHD_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .arg_ready(arg_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_method(wr_method), .wr_data(wr_data), .wr_remain(wr_remain),
  .busy(busy), .err(err)
);

// File: tb/tb_cmd_method_seq.sv
module tb_cmd_method_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_valid = 1'b0, hdr_ready;
  logic [12:0] hdr_method = '0;
  logic [2:0]  hdr_subch = '0;
  logic [12:0] hdr_count = '0;
  logic [2:0]  hdr_mode = '0;
  logic [12:0] hdr_imm = '0;
  logic arg_valid = 1'b0, arg_ready;
  logic [31:0] arg_data = '0;
  logic wr_valid, wr_ready;
  logic [12:0] wr_method;
  logic [2:0]  wr_subch;
  logic [31:0] wr_data;
  logic [12:0] wr_remain;
  logic busy, err;

  int total = 0, bad = 0;
  int cap_n = 0, arg_cnt = 0, err_cnt = 0, cyc = 0;
  bit stall_en = 0;
  logic [12:0] cap_m [0:63];
  logic [2:0]  cap_s [0:63];
  logic [31:0] cap_d [0:63];
  logic [12:0] cap_r [0:63];
  logic [31:0] args  [0:15];

  always #5 clk = ~clk;

  cmd_method_seq dut (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_method(hdr_method), .hdr_subch(hdr_subch), .hdr_count(hdr_count),
    .hdr_mode(hdr_mode), .hdr_imm(hdr_imm), .arg_valid(arg_valid),
    .arg_ready(arg_ready), .arg_data(arg_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_method(wr_method), .wr_subch(wr_subch),
    .wr_data(wr_data), .wr_remain(wr_remain), .busy(busy), .err(err)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    wr_ready <= stall_en ? ((cyc % 3) == 0) : 1'b1;
  end

  initial wr_ready = 1'b1;

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (wr_valid && wr_ready && cap_n < 64) begin
        cap_m[cap_n] = wr_method; cap_s[cap_n] = wr_subch;
        cap_d[cap_n] = wr_data;   cap_r[cap_n] = wr_remain;
        cap_n++;
      end
      if (arg_valid && arg_ready) arg_cnt++;
      if (err) err_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_m(input logic [2:0] md, input logic [12:0] b, input int i);
    case (md)
      3'd1:    return b;
      3'd2:    return (i == 0) ? b : b + 13'd1;
      default: return b + 13'(i);
    endcase
  endfunction

  task automatic send_hdr(input logic [2:0] md, input logic [12:0] b, input logic [2:0] sb,
                          input int n, input logic [12:0] imm);
    @(negedge clk);
    hdr_mode = md; hdr_method = b; hdr_subch = sb; hdr_count = 13'(n); hdr_imm = imm;
    hdr_valid = 1'b1;
    #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      arg_valid = 1'b1; arg_data = args[i];
      #1;
      while (!arg_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    arg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    repeat (3) @(negedge clk);
    #3;
    while (busy && g < 1000) begin @(negedge clk); #3; g++; end
  endtask

  task automatic run_hdr(input string req, input logic [2:0] md, input logic [12:0] b,
                         input logic [2:0] sb, input int n);
    int a0;
    for (int i = 0; i < 16; i++) args[i] = 32'h5A5A0000 ^ {8'(md), 8'(sb), 16'(i * 37 + 1)};
    cap_n = 0; a0 = arg_cnt;
    fork
      begin
        send_hdr(md, b, sb, n, 13'h0);
        #3;
        chk("R8", "busy after accept", {62'b0, busy, hdr_ready}, 64'h2);
      end
      feed(n);
    join
    wait_idle();
    chk("R9", "write count", 64'(cap_n), 64'(n));
    chk("R9", "args consumed", 64'(arg_cnt - a0), 64'(n));
    for (int i = 0; i < n && i < cap_n; i++) begin
      chk(req, "method", 64'(cap_m[i]), 64'(exp_m(md, b, i)));
      chk("R9", "data", 64'(cap_d[i]), 64'(args[i]));
      chk("R5", "remain", 64'(cap_r[i]), 64'(n - i - 1));
      chk("R6", "subch", 64'(cap_s[i]), 64'(sb));
    end
  endtask

  task automatic t_reset();
    #3;
    chk("R12", "reset outs", {59'b0, wr_valid, busy, err, arg_ready, hdr_ready}, 64'h1);
  endtask

  task automatic t_step();  run_hdr("R1", 3'd0, 13'h1FFC, 3'd5, 6); endtask
  task automatic t_fix();   run_hdr("R2", 3'd1, 13'h0E24, 3'd2, 4); endtask
  task automatic t_once();
    run_hdr("R3", 3'd2, 13'h0E00, 3'd1, 5);
    run_hdr("R3", 3'd2, 13'h0E40, 3'd6, 1);
  endtask
  task automatic t_stall();
    stall_en = 1;
    run_hdr("R1", 3'd0, 13'h0100, 3'd3, 12);
    run_hdr("R3", 3'd2, 13'h0200, 3'd4, 7);
    stall_en = 0;
  endtask

  task automatic t_inline();
    int a0, e0;
    cap_n = 0; a0 = arg_cnt; e0 = err_cnt;
    @(negedge clk); arg_valid = 1'b1; arg_data = 32'hDEADBEEF;
    send_hdr(3'd3, 13'h0120, 3'd7, 9, 13'h1ABC);
    wait_idle();
    chk("R4", "inline writes", 64'(cap_n), 64'd1);
    chk("R4", "inline method", 64'(cap_m[0]), 64'h0120);
    chk("R4", "inline data", 64'(cap_d[0]), 64'h1ABC);
    chk("R4", "inline remain", 64'(cap_r[0]), 64'd0);
    chk("R6", "inline subch", 64'(cap_s[0]), 64'd7);
    chk("R4", "inline args consumed", 64'(arg_cnt - a0), 64'd0);
    chk("R4", "inline no err", 64'(err_cnt - e0), 64'd0);
    arg_valid = 1'b0;
  endtask

  task automatic t_zero();
    int e0;
    for (int m = 0; m < 2; m++) begin
      cap_n = 0; e0 = err_cnt;
      send_hdr(3'(m), 13'h0300, 3'd1, 0, 13'h0);
      #3;
      chk("R7", "zero count idle", {63'b0, busy}, 64'd0);
      wait_idle();
      chk("R7", "zero count writes", 64'(cap_n), 64'd0);
      chk("R7", "zero count no err", 64'(err_cnt - e0), 64'd0);
    end
  endtask

  task automatic t_once_zero();
    int e0;
    cap_n = 0; e0 = err_cnt;
    send_hdr(3'd2, 13'h0400, 3'd2, 0, 13'h0);
    wait_idle();
    chk("R10", "err cycles", 64'(err_cnt - e0), 64'd1);
    chk("R10", "writes", 64'(cap_n), 64'd0);
  endtask

  task automatic t_bad_mode();
    int e0, a0;
    for (int m = 4; m < 8; m += 3) begin
      cap_n = 0; e0 = err_cnt; a0 = arg_cnt;
      @(negedge clk); arg_valid = 1'b1; arg_data = 32'h12345678;
      send_hdr(3'(m), 13'h0500, 3'd3, 3, 13'h0);
      wait_idle();
      chk("R11", "err cycles", 64'(err_cnt - e0), 64'd1);
      chk("R11", "writes", 64'(cap_n), 64'd0);
      chk("R11", "args consumed", 64'(arg_cnt - a0), 64'd0);
      arg_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_step();
    t_fix();
    t_once();
    t_inline();
    t_zero();
    t_once_zero();
    t_bad_mode();
    t_stall();
    t_step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule